// File: doc/BRIEF.md
# Serial Write Port for a Transceiver Control Register Bank

This block accepts control words from a host over a three-wire serial link: an active-low select, a serial clock and a data line. All three wires are sampled by the block's system clock, passed through two-stage synchronisers and edge-detected. While select is low, each rising edge of the serial clock shifts one data bit into a 24-bit frame register, most significant bit first. When select returns high, the frame is checked. It is committed only if exactly 24 bits were clocked in. The low four bits of the frame choose the target register, and the upper twenty bits carry its new contents.

The bank holds seven registers: a main and a reference divider for each of two synthesisers (RF and IF), a configuration word, an operational-control word and a test word. Each register presents only its meaningful bits on its output. The unused bits always read zero. Two shutdown paths exist. Pulling the shutdown pin low holds the whole block, serial port included, in its default state. Writing the software shutdown bit to 0 turns the controlled functions off and restores every register to its default, but leaves the serial port running so that a later write can turn the part back on. The standby bit turns functions off and keeps every register's contents.

The link is write-only and has no readback. The only status output is `func_en`, which is high when the controlled functions are enabled.

Top module: `ctl3w_port`

## Requirements
- R1: After reset the register outputs hold their defaults and `func_en` is 1. The defaults are: RF main 0x00D0E, RF ref 0x00064, IF main 0x00104, IF ref 0x00020, config 0x005C3, op-control 0x000C3, test 0x00000.
- R2: A frame has 24 bits sent MSB first. Frame bits [23:4] are the data and bits [3:0] are the address. On the rising edge of select, the data is written to the addressed register. The addresses are: 0 RF main, 1 RF ref, 2 IF main, 3 IF ref, 4 config, 5 op-control, 6 test.
- R3: Data is shifted only on rising serial-clock edges while select is low. Serial-clock activity while select is high has no effect.
- R4: A frame of any length other than 24 bits is discarded when select rises, and no register changes.
- R5: A frame addressed to 7 through 15 changes no register.
- R6: Bits outside each register's mask read 0. The masks are: dividers 0x1FFFF (main) and 0x03FFF (ref), config 0x0FFFF, op-control 0x003FF, test 0x000FF.
- R7: While `shdn_n` is low, every register holds its default, `func_en` is 0 and serial frames are ignored.
- R8: Writing op-control with bit 0 = 0 sets `func_en` to 0 and returns every register to its default. Later frames are still accepted. A later op-control write with bit 0 = 1 re-enables `func_en`.
- R9: Op-control bit 1 = 0 (standby) forces `func_en` to 0. All register contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shdn_n | input | 1 | Shutdown pin, active low, clears the whole block |
| ser_csn | input | 1 | Serial select, active low |
| ser_sck | input | 1 | Serial clock |
| ser_sdi | input | 1 | Serial data |
| rf_main_o | output | 20 | RF main divider |
| rf_ref_o | output | 20 | RF reference divider |
| if_main_o | output | 20 | IF main divider |
| if_ref_o | output | 20 | IF reference divider |
| cfg_o | output | 20 | Configuration word |
| opctl_o | output | 20 | Operational-control word |
| test_o | output | 20 | Test word |
| func_en | output | 1 | Controlled functions enabled |

## Verification
A wrong bit count or a wrong shift direction shows up as a register holding a rotated value, or as a write landing in the wrong register. Either appears on the outputs a few system clocks after select rises. A shutdown flag stuck in the wrong state shows immediately on `func_en`. It also shows as registers that fail to return to their defaults, or that fail to accept writes. The bench reads every output after each frame, so a stray write to any register is caught within the same scenario.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;
  localparam int FRAME_BITS = 24;
  localparam int ADDR_BITS  = 4;
  localparam int DATA_BITS  = FRAME_BITS - ADDR_BITS;
  localparam int NUM_REGS   = 7;

  localparam int IDX_OPCTL  = 5;
  localparam int SHUT_BIT   = 0;
  localparam int STBY_BIT   = 1;

  function automatic logic [DATA_BITS-1:0] reg_default(input int idx);
    case (idx)
      0:       return 20'h00D0E;
      1:       return 20'h00064;
      2:       return 20'h00104;
      3:       return 20'h00020;
      4:       return 20'h005C3;
      5:       return 20'h000C3;
      default: return 20'h00000;
    endcase
  endfunction

  function automatic logic [DATA_BITS-1:0] reg_mask(input int idx);
    case (idx)
      0, 2:    return 20'h1FFFF;
      1, 3:    return 20'h03FFF;
      4:       return 20'h0FFFF;
      5:       return 20'h003FF;
      default: return 20'h000FF;
    endcase
  endfunction
endpackage

// File: rtl/ctl3w_sync.sv
module ctl3w_sync #(
  parameter int WIDTH = 3,
  parameter logic [WIDTH-1:0] INIT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg1_q, stg2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= INIT;
      stg2_q <= INIT;
    end else if (clr_i) begin
      stg1_q <= INIT;
      stg2_q <= INIT;
    end else begin
      stg1_q <= d_i;
      stg2_q <= stg1_q;
    end
  end

  assign q_o = stg2_q;
endmodule

// File: rtl/ctl3w_shifter.sv
module ctl3w_shifter
  import ctl3w_pkg::*;
#(
  parameter int FBITS = FRAME_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             csn_i,
  input  logic             sck_i,
  input  logic             sdi_i,
  output logic             frame_vld_o,
  output logic [FBITS-1:0] frame_o
);
  localparam int CNT_W   = $clog2(FBITS + 2);
  localparam int CNT_MAX = FBITS + 1;

  logic             csn_d, sck_d;
  logic [CNT_W-1:0] cnt_q;
  logic [FBITS-1:0] shreg_q;
  logic             vld_q;
  logic             sck_rise, csn_rise;

  assign sck_rise = sck_i & ~sck_d;
  assign csn_rise = csn_i & ~csn_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csn_d   <= 1'b1;
      sck_d   <= 1'b0;
      cnt_q   <= '0;
      shreg_q <= '0;
      vld_q   <= 1'b0;
    end else if (clr_i) begin
      csn_d   <= 1'b1;
      sck_d   <= 1'b0;
      cnt_q   <= '0;
      shreg_q <= '0;
      vld_q   <= 1'b0;
    end else begin
      csn_d <= csn_i;
      sck_d <= sck_i;
      vld_q <= csn_rise && (cnt_q == CNT_W'(FBITS));
      if (csn_i) begin
        cnt_q <= '0;
      end else if (sck_rise) begin
        shreg_q <= {shreg_q[FBITS-2:0], sdi_i};
        if (cnt_q != CNT_W'(CNT_MAX)) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign frame_vld_o = vld_q;
  assign frame_o     = shreg_q;

  // R3: the frame register does not move while select is high
  p_hold_when_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (csn_i && !clr_i) |=> $stable(shreg_q));

  // R4: the bit counter never passes its saturation value
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(CNT_MAX));

  // R2: a commit is a single-cycle pulse
  p_commit_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_vld_o |=> !frame_vld_o);
endmodule

// File: rtl/ctl3w_bank.sv
module ctl3w_bank
  import ctl3w_pkg::*;
#(
  parameter int NREG = NUM_REGS,
  parameter int AW   = ADDR_BITS,
  parameter int DW   = DATA_BITS
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr_i,
  input  logic                     wr_i,
  input  logic [AW-1:0]            addr_i,
  input  logic [DW-1:0]            data_i,
  output logic [NREG-1:0][DW-1:0]  regs_o,
  output logic                     soft_shut_o
);
  logic [NREG-1:0][DW-1:0] regs_q;
  logic [NREG-1:0][DW-1:0] dflt;
  logic                    opctl_wr, soft_clr, soft_q;

  assign opctl_wr = wr_i && (addr_i == AW'(IDX_OPCTL));
  assign soft_clr = opctl_wr && !data_i[SHUT_BIT];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    assign dflt[i] = reg_default(i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[i] <= reg_default(i);
      end else if (clr_i || soft_clr) begin
        regs_q[i] <= reg_default(i);
      end else if (wr_i && (addr_i == AW'(i))) begin
        regs_q[i] <= data_i & reg_mask(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        soft_q <= 1'b0;
    else if (clr_i)    soft_q <= 1'b0;
    else if (opctl_wr) soft_q <= !data_i[SHUT_BIT];
  end

  assign regs_o      = regs_q;
  assign soft_shut_o = soft_q;

  // R5: a write to an unmapped address leaves the whole bank unchanged
  p_unmapped_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && (addr_i >= AW'(NREG)) && !clr_i) |=> $stable(regs_q));

  // R7: the pin clear puts every register back to its default
  p_pin_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (regs_q == dflt));

  // R8: a software shutdown write restores defaults and raises the flag
  p_soft_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_clr && !clr_i) |=> ((regs_q == dflt) && soft_shut_o));
endmodule

// File: rtl/ctl3w_port.sv
module ctl3w_port
  import ctl3w_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shdn_n,
  input  logic                 ser_csn,
  input  logic                 ser_sck,
  input  logic                 ser_sdi,
  output logic [DATA_BITS-1:0] rf_main_o,
  output logic [DATA_BITS-1:0] rf_ref_o,
  output logic [DATA_BITS-1:0] if_main_o,
  output logic [DATA_BITS-1:0] if_ref_o,
  output logic [DATA_BITS-1:0] cfg_o,
  output logic [DATA_BITS-1:0] opctl_o,
  output logic [DATA_BITS-1:0] test_o,
  output logic                 func_en
);
  logic                                clr;
  logic [2:0]                          pins_s;
  logic                                frame_vld;
  logic [FRAME_BITS-1:0]               frame;
  logic [NUM_REGS-1:0][DATA_BITS-1:0]  regs;
  logic                                soft_shut;

  assign clr = ~shdn_n;

  ctl3w_sync #(.WIDTH(3), .INIT(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (clr),
    .d_i   ({ser_csn, ser_sck, ser_sdi}),
    .q_o   (pins_s)
  );

  ctl3w_shifter #(.FBITS(FRAME_BITS)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (clr),
    .csn_i       (pins_s[2]),
    .sck_i       (pins_s[1]),
    .sdi_i       (pins_s[0]),
    .frame_vld_o (frame_vld),
    .frame_o     (frame)
  );

  ctl3w_bank #(.NREG(NUM_REGS), .AW(ADDR_BITS), .DW(DATA_BITS)) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (clr),
    .wr_i        (frame_vld),
    .addr_i      (frame[ADDR_BITS-1:0]),
    .data_i      (frame[FRAME_BITS-1:ADDR_BITS]),
    .regs_o      (regs),
    .soft_shut_o (soft_shut)
  );

  assign rf_main_o = regs[0];
  assign rf_ref_o  = regs[1];
  assign if_main_o = regs[2];
  assign if_ref_o  = regs[3];
  assign cfg_o     = regs[4];
  assign opctl_o   = regs[5];
  assign test_o    = regs[6];
  assign func_en   = shdn_n & ~soft_shut & regs[IDX_OPCTL][STBY_BIT];

  // R7: the pin holds the functions off
  p_pin_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_n |-> !func_en);

  // R9: a standby write turns functions off on the next cycle
  p_standby_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_vld && shdn_n && (frame[ADDR_BITS-1:0] == ADDR_BITS'(IDX_OPCTL))
     && !frame[ADDR_BITS+STBY_BIT]) |=> !func_en);
endmodule

// File: tb/ctl3w_port_tb.sv
module ctl3w_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shdn_n = 1'b1;
  logic ser_csn = 1'b1;
  logic ser_sck = 1'b0;
  logic ser_sdi = 1'b0;
  logic [19:0] rf_main_o, rf_ref_o, if_main_o, if_ref_o, cfg_o, opctl_o, test_o;
  logic func_en;

  int n_chk = 0;
  int n_bad = 0;
  logic [19:0] exp_r [7];
  logic [19:0] dflt  [7];
  logic [19:0] mask  [7];

  always #2.5 clk = ~clk;

  ctl3w_port dut_i (
    .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n),
    .ser_csn(ser_csn), .ser_sck(ser_sck), .ser_sdi(ser_sdi),
    .rf_main_o(rf_main_o), .rf_ref_o(rf_ref_o), .if_main_o(if_main_o),
    .if_ref_o(if_ref_o), .cfg_o(cfg_o), .opctl_o(opctl_o), .test_o(test_o),
    .func_en(func_en)
  );

  function automatic logic [19:0] out_of(input int i);
    case (i)
      0: return rf_main_o;
      1: return rf_ref_o;
      2: return if_main_o;
      3: return if_ref_o;
      4: return cfg_o;
      5: return opctl_o;
      default: return test_o;
    endcase
  endfunction

  task automatic chk(input string req, input logic [19:0] act, input logic [19:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%05h expected=%05h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    for (int i = 0; i < 7; i++) chk(req, out_of(i), exp_r[i]);
  endtask

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_bits(input logic [31:0] bits, input int n);
    ser_csn = 1'b0;
    wclk(3);
    for (int k = n - 1; k >= 0; k--) begin
      ser_sdi = bits[k];
      wclk(3);
      ser_sck = 1'b1;
      wclk(3);
      ser_sck = 1'b0;
    end
    wclk(3);
    ser_csn = 1'b1;
    wclk(8);
  endtask

  task automatic send_frame(input logic [19:0] d, input logic [3:0] a);
    send_bits({8'h0, d, a}, 24);
  endtask

  task automatic t_reset;
    chk_all("R1");
    chk("R1 func_en", {19'h0, func_en}, 20'h1);
  endtask

  task automatic t_write_each;
    for (int i = 0; i < 7; i++) begin
      send_frame(20'hFFFFF, 4'(i));
      exp_r[i] = mask[i];
    end
    chk_all("R6");
    send_frame(20'hA5A5A, 4'd0);
    exp_r[0] = 20'hA5A5A & mask[0];
    send_frame(20'h01357, 4'd3);
    exp_r[3] = 20'h01357 & mask[3];
    chk_all("R2");
  endtask

  task automatic t_idle_clock;
    ser_sdi = 1'b1;
    for (int k = 0; k < 10; k++) begin
      wclk(3); ser_sck = 1'b1; wclk(3); ser_sck = 1'b0;
    end
    send_frame(20'h01234, 4'd4);
    exp_r[4] = 20'h01234;
    chk_all("R3");
  endtask

  task automatic t_bad_len;
    send_bits({8'h0, 20'h000AB, 4'd6}, 23);
    chk_all("R4 short");
    send_bits({7'h0, 1'b1, 20'h000AB, 4'd6}, 25);
    chk_all("R4 long");
  endtask

  task automatic t_unmapped;
    send_frame(20'hFFFFF, 4'd7);
    send_frame(20'h00000, 4'd15);
    send_frame(20'h12345, 4'd9);
    chk_all("R5");
  endtask

  task automatic t_standby;
    send_frame(20'h00001, 4'd5);
    exp_r[5] = 20'h00001;
    chk("R9 func_en", {19'h0, func_en}, 20'h0);
    chk_all("R9 retained");
    send_frame(20'h00003, 4'd5);
    exp_r[5] = 20'h00003;
    chk("R9 resume", {19'h0, func_en}, 20'h1);
  endtask

  task automatic t_soft;
    send_frame(20'h0BEEF, 4'd4);
    send_frame(20'h00002, 4'd5);
    for (int i = 0; i < 7; i++) exp_r[i] = dflt[i];
    chk("R8 off", {19'h0, func_en}, 20'h0);
    chk_all("R8 defaults");
    send_frame(20'h00123, 4'd3);
    exp_r[3] = 20'h00123;
    chk("R8 port alive", if_ref_o, 20'h00123);
    send_frame(20'h00003, 4'd5);
    exp_r[5] = 20'h00003;
    chk("R8 on", {19'h0, func_en}, 20'h1);
    chk_all("R8 after");
  endtask

  task automatic t_pin;
    send_frame(20'h00055, 4'd6);
    exp_r[6] = 20'h00055;
    chk("R7 pre", test_o, 20'h00055);
    shdn_n = 1'b0;
    wclk(2);
    for (int i = 0; i < 7; i++) exp_r[i] = dflt[i];
    chk("R7 off", {19'h0, func_en}, 20'h0);
    chk_all("R7 defaults");
    send_frame(20'h00077, 4'd6);
    shdn_n = 1'b1;
    wclk(8);
    chk_all("R7 ignored");
    chk("R7 on", {19'h0, func_en}, 20'h1);
  endtask

  initial begin
    automatic int cyc = 0;
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    dflt[0] = 20'h00D0E; dflt[1] = 20'h00064; dflt[2] = 20'h00104;
    dflt[3] = 20'h00020; dflt[4] = 20'h005C3; dflt[5] = 20'h000C3;
    dflt[6] = 20'h00000;
    mask[0] = 20'h1FFFF; mask[1] = 20'h03FFF; mask[2] = 20'h1FFFF;
    mask[3] = 20'h03FFF; mask[4] = 20'h0FFFF; mask[5] = 20'h003FF;
    mask[6] = 20'h000FF;
    for (int i = 0; i < 7; i++) exp_r[i] = dflt[i];
    wclk(4);
    rst_n = 1'b1;
    wclk(4);
    t_reset();
    t_write_each();
    t_idle_clock();
    t_bad_len();
    t_unmapped();
    t_standby();
    t_soft();
    t_pin();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule